// File: doc/BRIEF.md
# Prescaled Auto-Reload Update Timer

This block produces a periodic, single-cycle update pulse from a fast clock. Its clock is divided in three cascaded stages. A prescaler counts from zero up to its limit, inclusive. A main up-counter advances once per prescaler wrap and returns to zero after it reaches the auto-reload limit, inclusive. A repetition counter then passes only one in every RCR+1 main-counter wraps. The update rate is therefore clk / ((PSC+1)(ARR+1)(RCR+1)).

Software-style settings reach the block through a data bus and a write strobe for each setting. Each write lands in a preload copy. The preload copies move into the working copies only when an update fires, so a period that has already started always runs to its end. Every update also sets a sticky event flag, which stays set until it is cleared. The live main-counter value is visible on an output. Dropping the enable freezes all of the counting.

Top module: `prescaled_update_timer`

## Requirements
- R1: While reset is asserted and after it is released, `update` and `flag` are 0 and `count` is 0. All working and preload settings reset to 0.
- R2: With enable high, `count` advances by one every PSC+1 clocks, runs from 0 to ARR inclusive, and then returns to 0.
- R3: With enable held high, consecutive `update` pulses are exactly (PSC+1)(ARR+1)(RCR+1) clocks apart. Each pulse lasts one cycle and appears in the cycle after the edge on which the final count is reached.
- R4: The repetition counter reloads with RCR on every update and decrements on each main-counter wrap. An update fires only on a wrap taken while the repetition counter is zero, so RCR=0 gives an update on every wrap.
- R5: A write to PSC, ARR or RCR changes only the preload copy. The new value takes effect at the next update, so the period that is running keeps its old length. Because the working values reset to 0, the first enabled clock after reset produces an update that loads the preload copies.
- R6: `flag` rises together with each `update` pulse. It stays at 1 until `clr_flag` is sampled high. If a clear and an update fall on the same edge, the flag stays set.
- R7: While `en` is low, the prescaler, the main counter and the repetition counter all hold, and no update fires. Counting resumes from the same point when `en` returns.
- R8: With PSC=0, ARR=0 and RCR=0, an update fires on every enabled clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Counting enable |
| psc_wdata | input | PSC_W | Prescaler limit write data |
| psc_we | input | 1 | Write strobe for the prescaler preload |
| arr_wdata | input | ARR_W | Auto-reload limit write data |
| arr_we | input | 1 | Write strobe for the auto-reload preload |
| rcr_wdata | input | RCR_W | Repetition count write data |
| rcr_we | input | 1 | Write strobe for the repetition preload |
| clr_flag | input | 1 | Clears the sticky event flag |
| update | output | 1 | One-cycle update event |
| flag | output | 1 | Sticky event flag |
| count | output | ARR_W | Live main-counter value |

## Verification
The assertions assume that `en` and `clr_flag` are plain synchronous levels sampled at each edge. They also assume that a preload write may arrive at any edge, including the edge on which an update fires. The bench changes every input only on the falling edge and gives each strobe exactly one rising edge. It places one clear on the same edge as an update and one preload write in the middle of a running period. It also pauses the enable while the counters hold non-zero values.

// File: rtl/prescaled_update_timer.sv
module prescaled_update_timer #(
  parameter int PSC_W = 16,
  parameter int ARR_W = 16,
  parameter int RCR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc_wdata,
  input  logic             psc_we,
  input  logic [ARR_W-1:0] arr_wdata,
  input  logic             arr_we,
  input  logic [RCR_W-1:0] rcr_wdata,
  input  logic             rcr_we,
  input  logic             clr_flag,
  output logic             update,
  output logic             flag,
  output logic [ARR_W-1:0] count
);

  logic [PSC_W-1:0] psc_pre, psc_act, pre_q;
  logic [ARR_W-1:0] arr_pre, arr_act, cnt_q;
  logic [RCR_W-1:0] rcr_pre, rep_q;
  logic             upd_q, flag_q;

  wire tick = en && (pre_q == psc_act);
  wire wrap = tick && (cnt_q == arr_act);
  wire fire = wrap && (rep_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_pre <= '0;
      arr_pre <= '0;
      rcr_pre <= '0;
    end else begin
      if (psc_we) psc_pre <= psc_wdata;
      if (arr_we) arr_pre <= arr_wdata;
      if (rcr_we) rcr_pre <= rcr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_act <= '0;
      arr_act <= '0;
    end else if (fire) begin
      psc_act <= psc_pre;
      arr_act <= arr_pre;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      rep_q <= '0;
    end else if (en) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) rep_q <= fire ? rcr_pre : rep_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      upd_q  <= fire;
      flag_q <= fire | (flag_q & ~clr_flag);
    end
  end

  assign update = upd_q;
  assign flag   = flag_q;
  assign count  = cnt_q;

endmodule

module prescaled_update_timer_chk #(
  parameter int ARR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             clr_flag,
  input logic             update,
  input logic             flag,
  input logic [ARR_W-1:0] count,
  input logic [ARR_W-1:0] arr_act
);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= arr_act);

  p_upd_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> $past(en));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

  p_flag_with_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> flag);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_flag) |=> flag);

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && clr_flag) |=> (!flag || update));

endmodule

bind prescaled_update_timer prescaled_update_timer_chk #(.ARR_W(ARR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .clr_flag(clr_flag),
  .update(update), .flag(flag), .count(count), .arr_act(arr_act)
);

// File: tb/prescaled_update_timer_tb_top.sv
module prescaled_update_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] psc_wdata = '0;
  logic        psc_we = 1'b0;
  logic [15:0] arr_wdata = '0;
  logic        arr_we = 1'b0;
  logic [7:0]  rcr_wdata = '0;
  logic        rcr_we = 1'b0;
  logic        clr_flag = 1'b0;
  logic        update, flag;
  logic [15:0] count;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int t0 = 0;
  bit finished = 1'b0;
  int exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prescaled_update_timer dut_i (
    .clk(clk), .rst_n(rst_n), .en(en),
    .psc_wdata(psc_wdata), .psc_we(psc_we),
    .arr_wdata(arr_wdata), .arr_we(arr_we),
    .rcr_wdata(rcr_wdata), .rcr_we(rcr_we),
    .clr_flag(clr_flag), .update(update), .flag(flag), .count(count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic write_cfg(input int p, input int a, input int r);
    psc_wdata = 16'(p); arr_wdata = 16'(a); rcr_wdata = 8'(r);
    psc_we = 1'b1; arr_we = 1'b1; rcr_we = 1'b1;
    @(negedge clk);
    psc_we = 1'b0; arr_we = 1'b0; rcr_we = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Monitor: pops expected update cycles and compares (R3, R4, R5, R8)
  always @(negedge clk) begin
    if (rst_n && update) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected update", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R3 update timing", cyc, e);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(update == 1'b0, "R1 update in reset", int'(update), 0);
    chk(flag == 1'b0, "R1 flag in reset", int'(flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == 0, "R1 count after reset", int'(count), 0);
    chk(update == 1'b0, "R1 no update while disabled", int'(update), 0);

    write_cfg(2, 3, 0);
    en = 1'b1;
    t0 = cyc + 1;
    // R5 first update loads preload; R3 period 12; R7 hold shifts by 5
    exp_q.push_back(t0);      exp_q.push_back(t0 + 12); exp_q.push_back(t0 + 24);
    exp_q.push_back(t0 + 41);
    // R5 mid-period ARR change: old period ends at t0+53, new period 6
    exp_q.push_back(t0 + 53); exp_q.push_back(t0 + 59); exp_q.push_back(t0 + 65);
    // R4 repetition 2 becomes active after t0+71: period 18
    exp_q.push_back(t0 + 71); exp_q.push_back(t0 + 89); exp_q.push_back(t0 + 107);
    // R8 all-zero setting: every enabled clock
    exp_q.push_back(t0 + 125); exp_q.push_back(t0 + 126);
    exp_q.push_back(t0 + 127); exp_q.push_back(t0 + 128);

    wait_to(t0);
    chk(flag == 1'b1, "R6 flag rises with update", int'(flag), 1);
    chk(count == 0, "R2 count at period start", int'(count), 0);
    wait_to(t0 + 3);  chk(count == 1, "R2 count step", int'(count), 1);
    wait_to(t0 + 6);  chk(count == 2, "R2 count step", int'(count), 2);
    wait_to(t0 + 9);  chk(count == 3, "R2 count at ARR", int'(count), 3);
    wait_to(t0 + 12); chk(count == 0, "R2 count wraps", int'(count), 0);

    wait_to(t0 + 28);
    chk(count == 1, "R2 count before pause", int'(count), 1);
    en = 1'b0;
    wait_to(t0 + 33);
    chk(count == 1, "R7 count held while disabled", int'(count), 1);
    en = 1'b1;

    wait_to(t0 + 46);
    arr_wdata = 16'd1; arr_we = 1'b1;
    @(negedge clk);
    arr_we = 1'b0;
    wait_to(t0 + 50);
    chk(count == 3, "R5 old ARR still active", int'(count), 3);

    wait_to(t0 + 54);
    clr_flag = 1'b1;
    @(negedge clk);
    clr_flag = 1'b0;
    chk(flag == 1'b0, "R6 flag cleared", int'(flag), 0);
    wait_to(t0 + 58); chk(flag == 1'b0, "R6 flag stays clear", int'(flag), 0);
    wait_to(t0 + 59); chk(flag == 1'b1, "R6 flag set again", int'(flag), 1);
    wait_to(t0 + 64);
    clr_flag = 1'b1;
    @(negedge clk);
    clr_flag = 1'b0;
    chk(flag == 1'b1, "R6 set wins over clear", int'(flag), 1);

    wait_to(t0 + 66);
    rcr_wdata = 8'd2; rcr_we = 1'b1;
    @(negedge clk);
    rcr_we = 1'b0;

    wait_to(t0 + 108);
    write_cfg(0, 0, 0);
    wait_to(t0 + 128);
    en = 1'b0;
    wait_to(t0 + 140);
    chk(update == 1'b0, "R7 no update while disabled", int'(update), 0);
    chk(exp_q.size() == 0, "R3 all expected updates seen", exp_q.size(), 0);
    finished = 1'b1;
    summary();
  end
endmodule